// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Controller with Sequential Stream Buffer

This block tracks which memory blocks are present in a direct-mapped cache and in a small two-entry stream buffer beside it. It stores tags and presence only; data payloads live elsewhere. A processor presents one byte address at a time through a valid/ready handshake. The block answers with a one-cycle response that says whether the access hit and which structure supplied the block: the cache, the stream buffer, or memory.

When an access misses both structures, the block sends a demand fill to memory. It also loads the stream buffer with the two blocks that follow the missing one. When an access hits the stream buffer, the block moves into its cache line and the buffer asks for the next block in sequence. A strictly sequential walk through memory therefore costs one miss at its start. The memory side takes block requests with a valid/ready handshake and returns tagged completions after any latency. Four counters expose the totals for accesses, cache hits, buffer hits and misses.

Top module: `stream_prefetch_cache`

## Requirements
- R1: A block address is the byte address with its low log2(BLOCK_BYTES) bits removed. The cache line is picked by the next log2(CACHE_BYTES/BLOCK_BYTES) bits, and the rest forms the tag. Any byte of an installed block hits in the cache. A block with the same line index but a different tag misses and replaces the old block.
- R2: An access that misses both structures responds with source code 2 (memory) and hit low. It issues a demand fill for its block address with request id 2, and installs the block when the id-2 completion arrives.
- R3: After a demand fill for block B, the stream buffer requests blocks B+1 and B+2. These use ids 0 and 1 (one id per buffer entry), with the older entry's request going out first.
- R4: An access that misses the cache but matches a ready buffer entry responds with source code 1 and hit high. The block is installed in its cache line, so a later access to it responds with source code 0 (cache).
- R5: After a buffer hit, the freed entry requests the block that follows the newest block the buffer has been assigned.
- R6: A hit on the younger buffer entry also discards the older entry. The discarded block then misses on a later access, and the buffer refills with the next two sequential blocks.
- R7: A miss in both structures flushes the buffer. Prefetching then restarts from the missing block address plus one.
- R8: An access matching a buffer entry whose fill is still outstanding waits for that completion and then responds as a buffer hit (source code 1).
- R9: Demand fills take priority over prefetches on the memory request port. The first request after a double miss is the id-2 demand request, and a demand request is never presented while the block is idle.
- R10: The access counter equals the sum of the cache-hit, buffer-hit and miss counters. A stride-2 byte walk from address 0 over 16 blocks gives exactly 1 miss, 15 buffer hits and 240 cache hits.
- R11: Reset clears every cache valid bit, empties the buffer, zeroes the counters, raises req_ready_o and lowers both response and memory-request valids.
- R12: One access is in flight at a time. req_ready_o drops in the cycle after an access is accepted and returns with the response. rsp_valid_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor access valid |
| req_ready_o | output | 1 | Block can accept an access |
| req_addr_i | input | ADDR_W | Byte address of the access |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | Access counted as a hit |
| rsp_src_o | output | 2 | Supplier: 0 cache, 1 stream buffer, 2 memory |
| mem_req_valid_o | output | 1 | Block-fill request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_blk_o | output | ADDR_W-log2(BLOCK_BYTES) | Requested block address |
| mem_req_id_o | output | 2 | 0/1 buffer entry, 2 demand fill |
| mem_cpl_valid_i | input | 1 | Fill completion |
| mem_cpl_id_i | input | 2 | Id of the completed request |
| acc_cnt_o | output | CNT_W | Total accesses answered |
| chit_cnt_o | output | CNT_W | Cache hits |
| bhit_cnt_o | output | CNT_W | Stream-buffer hits |
| miss_cnt_o | output | CNT_W | Misses |

## Verification
Two kinds of internal fault show up at the ports. A stale valid bit or a wrong tag shows up on the next access to that line as a wrong source code, two cycles after the request is accepted. A buffer entry holding the wrong block address, or a wrong FIFO order, shows up first in the block address or id on the memory request port. Its effect on responses appears only when the stream reaches that block, which can be several accesses later. For that reason the bench logs every memory request and checks its contents, and does not rely on response codes alone. The sequential walk checks the counters to confirm that no block transition was lost or double-counted.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY  = 2'd0,
    SLOT_QUEUED = 2'd1,
    SLOT_PEND   = 2'd2,
    SLOT_READY  = 2'd3
  } slot_st_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_CHECK, ST_DREQ, ST_DWAIT
  } ctrl_st_e;

  localparam int unsigned SLOTS = 2;
  localparam logic [1:0] SRC_CACHE = 2'd0;
  localparam logic [1:0] SRC_BUF   = 2'd1;
  localparam logic [1:0] SRC_MEM   = 2'd2;
  localparam logic [1:0] ID_DEMAND = 2'd2;
endpackage

// File: rtl/sbp_tag_array.sv
module sbp_tag_array #(
  parameter int LINES = 2048,
  parameter int IDX_W = 11,
  parameter int TAG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             hit_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  // tags need no reset: valid gates them
  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  assign hit_o = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
endmodule

// File: rtl/sbp_stream_buf.sv
module sbp_stream_buf
  import sbp_pkg::*;
#(
  parameter int BLK_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] look_blk_i,
  output logic             match_o,
  output logic             match_ready_o,
  input  logic             restart_i,
  input  logic [BLK_W-1:0] restart_blk_i,
  input  logic             pop_i,
  input  logic             issue_en_i,
  output logic             pf_valid_o,
  output logic [BLK_W-1:0] pf_blk_o,
  output logic             pf_slot_o,
  input  logic             pf_fire_i,
  input  logic             cpl_valid_i,
  input  logic             cpl_slot_i
);
  slot_st_e         st_q  [SLOTS];
  logic [BLK_W-1:0] blk_q [SLOTS];
  logic [SLOTS-1:0] infl_q;
  logic             hd_q;
  logic [BLK_W-1:0] nxt_q;

  logic [SLOTS-1:0] hit_s, issuable_s;
  logic             mslot, second;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign hit_s[s]      = (st_q[s] != SLOT_EMPTY) && (blk_q[s] == look_blk_i);
    assign issuable_s[s] = (st_q[s] == SLOT_QUEUED) && !infl_q[s];
  end

  assign match_o       = |hit_s;
  assign second        = !hit_s[hd_q];
  assign mslot         = second ? ~hd_q : hd_q;
  assign match_ready_o = (st_q[mslot] == SLOT_READY);

  // older entry issues first
  assign pf_slot_o  = issuable_s[hd_q] ? hd_q : ~hd_q;
  assign pf_valid_o = issue_en_i && (|issuable_s);
  assign pf_blk_o   = blk_q[pf_slot_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SLOTS; s++) begin
        st_q[s]  <= SLOT_EMPTY;
        blk_q[s] <= '0;
      end
      infl_q <= '0;
      hd_q   <= 1'b0;
      nxt_q  <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (cpl_valid_i && (cpl_slot_i == 1'(s))) begin
          infl_q[s] <= 1'b0;
          if (st_q[s] == SLOT_PEND) st_q[s] <= SLOT_READY;
        end
      end
      if (pf_fire_i) begin
        st_q[pf_slot_o]   <= SLOT_PEND;
        infl_q[pf_slot_o] <= 1'b1;
      end
      // a flushed entry keeps its in-flight bit so a stale completion is absorbed
      if (restart_i) begin
        st_q[hd_q]   <= SLOT_QUEUED;
        blk_q[hd_q]  <= restart_blk_i + BLK_W'(1);
        st_q[~hd_q]  <= SLOT_QUEUED;
        blk_q[~hd_q] <= restart_blk_i + BLK_W'(2);
        nxt_q        <= restart_blk_i + BLK_W'(3);
      end else if (pop_i) begin
        st_q[hd_q]  <= SLOT_QUEUED;
        blk_q[hd_q] <= nxt_q;
        if (second) begin
          st_q[~hd_q]  <= SLOT_QUEUED;
          blk_q[~hd_q] <= nxt_q + BLK_W'(1);
          nxt_q        <= nxt_q + BLK_W'(2);
        end else begin
          hd_q  <= ~hd_q;
          nxt_q <= nxt_q + BLK_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/stream_prefetch_cache.sv
module stream_prefetch_cache
  import sbp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 65536,
  parameter int BLOCK_BYTES = 32,
  parameter int CNT_W       = 32
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   req_valid_i,
  output logic                                   req_ready_o,
  input  logic [ADDR_W-1:0]                      req_addr_i,
  output logic                                   rsp_valid_o,
  output logic                                   rsp_hit_o,
  output logic [1:0]                             rsp_src_o,
  output logic                                   mem_req_valid_o,
  input  logic                                   mem_req_ready_i,
  output logic [ADDR_W-$clog2(BLOCK_BYTES)-1:0]  mem_req_blk_o,
  output logic [1:0]                             mem_req_id_o,
  input  logic                                   mem_cpl_valid_i,
  input  logic [1:0]                             mem_cpl_id_i,
  output logic [CNT_W-1:0]                       acc_cnt_o,
  output logic [CNT_W-1:0]                       chit_cnt_o,
  output logic [CNT_W-1:0]                       bhit_cnt_o,
  output logic [CNT_W-1:0]                       miss_cnt_o
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int LINES = CACHE_BYTES / BLOCK_BYTES;
  localparam int IDX_W = $clog2(LINES);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int TAG_W = BLK_W - IDX_W;

  ctrl_st_e         st_q, st_d;
  logic [BLK_W-1:0] cur_blk_q;
  logic             cache_hit, install;
  logic             sb_match, sb_match_ready, sb_restart, sb_pop;
  logic             pf_valid, pf_slot, pf_fire;
  logic [BLK_W-1:0] pf_blk;
  logic             resp_fire;
  logic [1:0]       resp_src;
  logic             rsp_valid_q;
  logic [1:0]       rsp_src_q;
  logic             dem_cpl;

  sbp_tag_array #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (cur_blk_q[IDX_W-1:0]),
    .rd_tag_i (cur_blk_q[BLK_W-1:IDX_W]),
    .hit_o    (cache_hit),
    .wr_en_i  (install),
    .wr_idx_i (cur_blk_q[IDX_W-1:0]),
    .wr_tag_i (cur_blk_q[BLK_W-1:IDX_W])
  );

  sbp_stream_buf #(.BLK_W(BLK_W)) u_sbuf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .look_blk_i    (cur_blk_q),
    .match_o       (sb_match),
    .match_ready_o (sb_match_ready),
    .restart_i     (sb_restart),
    .restart_blk_i (cur_blk_q),
    .pop_i         (sb_pop),
    .issue_en_i    (st_q != ST_DREQ),
    .pf_valid_o    (pf_valid),
    .pf_blk_o      (pf_blk),
    .pf_slot_o     (pf_slot),
    .pf_fire_i     (pf_fire),
    .cpl_valid_i   (mem_cpl_valid_i && (mem_cpl_id_i != ID_DEMAND)),
    .cpl_slot_i    (mem_cpl_id_i[0])
  );

  assign dem_cpl = mem_cpl_valid_i && (mem_cpl_id_i == ID_DEMAND);

  always_comb begin
    st_d       = st_q;
    resp_fire  = 1'b0;
    resp_src   = SRC_CACHE;
    install    = 1'b0;
    sb_restart = 1'b0;
    sb_pop     = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i) st_d = ST_CHECK;
      ST_CHECK: begin
        if (cache_hit) begin
          resp_fire = 1'b1;
          st_d      = ST_IDLE;
        end else if (sb_match) begin
          // pending match: hold here until the fill lands
          if (sb_match_ready) begin
            sb_pop    = 1'b1;
            install   = 1'b1;
            resp_fire = 1'b1;
            resp_src  = SRC_BUF;
            st_d      = ST_IDLE;
          end
        end else begin
          sb_restart = 1'b1;
          st_d       = ST_DREQ;
        end
      end
      ST_DREQ:  if (mem_req_ready_i) st_d = ST_DWAIT;
      ST_DWAIT: if (dem_cpl) begin
        install   = 1'b1;
        resp_fire = 1'b1;
        resp_src  = SRC_MEM;
        st_d      = ST_IDLE;
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  assign mem_req_valid_o = (st_q == ST_DREQ) || pf_valid;
  assign mem_req_blk_o   = (st_q == ST_DREQ) ? cur_blk_q : pf_blk;
  assign mem_req_id_o    = (st_q == ST_DREQ) ? ID_DEMAND : {1'b0, pf_slot};
  assign pf_fire         = pf_valid && mem_req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cur_blk_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_src_q   <= SRC_CACHE;
      acc_cnt_o   <= '0;
      chit_cnt_o  <= '0;
      bhit_cnt_o  <= '0;
      miss_cnt_o  <= '0;
    end else begin
      st_q        <= st_d;
      rsp_valid_q <= resp_fire;
      if (st_q == ST_IDLE && req_valid_i) cur_blk_q <= req_addr_i[ADDR_W-1:OFF_W];
      if (resp_fire) begin
        rsp_src_q <= resp_src;
        acc_cnt_o <= acc_cnt_o + CNT_W'(1);
        unique case (resp_src)
          SRC_CACHE: chit_cnt_o <= chit_cnt_o + CNT_W'(1);
          SRC_BUF:   bhit_cnt_o <= bhit_cnt_o + CNT_W'(1);
          default:   miss_cnt_o <= miss_cnt_o + CNT_W'(1);
        endcase
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_src_o   = rsp_src_q;
  assign rsp_hit_o   = rsp_valid_q && (rsp_src_q != SRC_MEM);
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic             mem_req_valid_o,
  input logic [1:0]       mem_req_id_o,
  input logic [CNT_W-1:0] acc_cnt_o,
  input logic [CNT_W-1:0] chit_cnt_o,
  input logic [CNT_W-1:0] bhit_cnt_o,
  input logic [CNT_W-1:0] miss_cnt_o
);
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R12

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R12

  AST_CNT_BALANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_cnt_o == chit_cnt_o + bhit_cnt_o + miss_cnt_o); // R10

  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> acc_cnt_o == $past(acc_cnt_o) + CNT_W'(1)); // R10

  AST_NO_DEMAND_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !(mem_req_valid_o && mem_req_id_o == 2'd2)); // R9

  AST_ID_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_id_o != 2'd3); // R3
endmodule

bind stream_prefetch_cache sbp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .rsp_valid_o     (rsp_valid_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_id_o    (mem_req_id_o),
  .acc_cnt_o       (acc_cnt_o),
  .chit_cnt_o      (chit_cnt_o),
  .bhit_cnt_o      (bhit_cnt_o),
  .miss_cnt_o      (miss_cnt_o)
);

// File: tb/stream_prefetch_cache_tb.sv
`timescale 1ns/1ps
module stream_prefetch_cache_tb;
  localparam int ADDR_W = 32;
  localparam int BLK_W  = 27;
  localparam int CNT_W  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready, rsp_valid, rsp_hit;
  logic [1:0]        rsp_src;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b1;
  logic [BLK_W-1:0]  mem_req_blk;
  logic [1:0]        mem_req_id;
  logic              mem_cpl_valid = 1'b0;
  logic [1:0]        mem_cpl_id = '0;
  logic [CNT_W-1:0]  acc_cnt, chit_cnt, bhit_cnt, miss_cnt;

  always #2.5 clk = ~clk;

  stream_prefetch_cache u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_src_o(rsp_src),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_blk_o(mem_req_blk), .mem_req_id_o(mem_req_id),
    .mem_cpl_valid_i(mem_cpl_valid), .mem_cpl_id_i(mem_cpl_id),
    .acc_cnt_o(acc_cnt), .chit_cnt_o(chit_cnt), .bhit_cnt_o(bhit_cnt), .miss_cnt_o(miss_cnt)
  );

  int n_chk = 0, n_fail = 0;
  int dem_lat = 3, pf_lat = 3;
  int log_n = 0;
  logic [BLK_W-1:0] log_blk [512];
  logic [1:0]       log_id  [512];
  bit busy_seen = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit log_has(input logic [BLK_W-1:0] b);
    for (int i = 0; i < log_n; i++) if (log_blk[i] == b) return 1'b1;
    return 1'b0;
  endfunction

  // memory model: per-id countdown, one completion per cycle
  initial begin
    bit busy [3];
    int tmr  [3];
    bit done;
    forever begin
      @(negedge clk);
      mem_cpl_valid = 1'b0;
      if (!rst_n) begin
        for (int i = 0; i < 3; i++) begin busy[i] = 0; tmr[i] = 0; end
      end else begin
        done = 0;
        for (int i = 0; i < 3; i++)
          if (!done && busy[i] && tmr[i] == 0) begin
            mem_cpl_valid = 1'b1; mem_cpl_id = 2'(i); busy[i] = 0; done = 1;
          end
        for (int i = 0; i < 3; i++) if (busy[i] && tmr[i] > 0) tmr[i]--;
        if (mem_req_valid && mem_req_ready && mem_req_id != 2'd3) begin
          busy[mem_req_id] = 1;
          tmr[mem_req_id]  = (mem_req_id == 2'd2) ? dem_lat : pf_lat;
          if (log_n < 512) begin
            log_blk[log_n] = mem_req_blk; log_id[log_n] = mem_req_id; log_n++;
          end
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    log_n = 0;
    rst_n = 1'b1;
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, output logic [1:0] src, output logic hit);
    int t;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk);
    #1 req_valid = 1'b0;
    t = 0;
    @(negedge clk);
    if (!busy_seen) begin
      busy_seen = 1;
      chk(req_ready == 1'b0, "R12", "ready after accept", req_ready, 0);
    end
    while (!rsp_valid && t < 2000) begin @(negedge clk); t++; end
    if (t >= 2000) chk(1'b0, "R12", "response timeout", t, 0);
    src = rsp_src; hit = rsp_hit;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12", "response pulse width", rsp_valid, 0);
  endtask

  // {byte address, expected source}
  localparam logic [33:0] VEC [13] = '{
    {32'h0000_0000, 2'd2},  // cold miss
    {32'h0000_0004, 2'd0},  // same block, other byte (R1)
    {32'h0000_0020, 2'd1},  // buffer head
    {32'h0000_0040, 2'd1},
    {32'h0000_0000, 2'd0},
    {32'h0000_1000, 2'd2},  // new stream (R7)
    {32'h0000_1040, 2'd1},  // younger entry (R6)
    {32'h0000_1020, 2'd2},  // discarded head misses (R6)
    {32'h0001_0000, 2'd2},  // line 0 conflict (R1)
    {32'h0000_0000, 2'd2},  // evicted
    {32'h0000_0020, 2'd0},  // installed by buffer hit (R4)
    {32'h0000_0040, 2'd0},
    {32'h0000_0060, 2'd2}   // stale buffer does not match
  };

  initial begin
    logic [1:0] s;
    logic h;
    string tg;

    do_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R11", "quiet after reset",
        {rsp_valid, mem_req_valid}, 0);
    chk(acc_cnt == 0 && miss_cnt == 0 && bhit_cnt == 0 && chit_cnt == 0, "R11",
        "counters after reset", acc_cnt + miss_cnt + bhit_cnt + chit_cnt, 0);

    for (int i = 0; i < 13; i++) begin
      access(VEC[i][33:2], s, h);
      tg = (VEC[i][1:0] == 2'd0) ? "R1" : (VEC[i][1:0] == 2'd1) ? "R4" : "R7";
      chk(s == VEC[i][1:0], tg, $sformatf("vector %0d source", i), s, VEC[i][1:0]);
      chk(h == (VEC[i][1:0] != 2'd2), "R2", $sformatf("vector %0d hit", i), h, VEC[i][1:0] != 2'd2);
    end

    chk(log_blk[0] == 0 && log_id[0] == 2'd2, "R9", "first request is demand", log_id[0], 2);
    chk(log_blk[1] == 1 && log_id[1] != 2'd2, "R3", "prefetch B+1", log_blk[1], 1);
    chk(log_blk[2] == 2 && log_id[2] != 2'd2, "R3", "prefetch B+2", log_blk[2], 2);
    chk(log_has(3) && log_has(4), "R5", "refill after buffer hits", log_has(3) + log_has(4), 2);
    chk(log_has(131) && log_has(132), "R6", "two refills after younger hit",
        log_has(131) + log_has(132), 2);
    chk(log_has(129) && log_has(130), "R7", "restart after new miss",
        log_has(129) + log_has(130), 2);
    chk(acc_cnt == 13, "R10", "access count", acc_cnt, 13);
    chk(miss_cnt == 6, "R10", "miss count", miss_cnt, 6);
    chk(bhit_cnt == 3, "R10", "buffer hit count", bhit_cnt, 3);
    chk(chit_cnt == 4, "R10", "cache hit count", chit_cnt, 4);

    // reset wipes installed lines
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(acc_cnt == 0 && req_ready == 1'b1, "R11", "state during reset", acc_cnt, 0);
    @(negedge clk);
    log_n = 0;
    rst_n = 1'b1;
    access(32'h4, s, h);
    chk(s == 2'd2, "R11", "line invalid after reset", s, 2);
    access(32'h20, s, h);
    chk(s == 2'd1, "R11", "buffer restarted after reset", s, 1);

    // slow prefetch: access waits on a pending entry
    dem_lat = 3; pf_lat = 40;
    do_reset();
    access(32'h0, s, h);
    chk(s == 2'd2, "R8", "cold miss before stall", s, 2);
    access(32'h20, s, h);
    chk(s == 2'd1 && h == 1'b1, "R8", "pending entry becomes buffer hit", s, 1);
    chk(miss_cnt == 1 && bhit_cnt == 1, "R8", "counts after stall", miss_cnt, 1);

    // sequential stride-2 walk
    dem_lat = 4; pf_lat = 4;
    do_reset();
    for (int i = 0; i < 256; i++) access(ADDR_W'(2 * i), s, h);
    chk(acc_cnt == 256, "R10", "walk accesses", acc_cnt, 256);
    chk(miss_cnt == 1, "R10", "walk misses", miss_cnt, 1);
    chk(bhit_cnt == 15, "R10", "walk buffer hits", bhit_cnt, 15);
    chk(chit_cnt == 240, "R10", "walk cache hits", chit_cnt, 240);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog: actual %0d expected %0d", 150000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule